// File: doc/BRIEF.md
# Erase Suspend and Resume Controller

This block sits beside the host write decoder of a flash-style memory and governs a sector erase that can be paused and continued. It collects the sectors named by sector-erase loads, holds an acceptance window that restarts on every load, then hands the work to the erase engine. A suspend byte can pause the job at once while the window is still open. During the erase proper, the pause is reached only after the engine reports a halt or after a bounded count of microsecond ticks.

While the job is paused, every read or program access is classified by sector. Sectors picked for erase answer with a status word, and the block refuses programs to them. Every other sector behaves normally. Chip erase and embedded programming are seen only as busy levels, and suspend bytes are dropped while either one runs.

Top module: `esr_ctrl`

## Requirements
- R1: The suspend byte 0xB0 (no address is taken) acts only in phase WINDOW or ERASING, and only with `chip_busy` and `prog_busy` low. In any other case the phase is left unchanged.
- R2: A `se_load` in IDLE enters WINDOW and marks its sector. Each further load in WINDOW marks another sector and restarts the window. The WIN_US-th tick after the last load moves the block to ERASING, with `eng_run` high.
- R3: A suspend accepted in WINDOW gives SUSPENDED at the next clock edge.
- R4: A suspend accepted in ERASING gives SUSPENDING, with `busy` still high. The block reaches SUSPENDED on the edge where `eng_halted` is seen, or at the SUSP_US-th tick, whichever comes first.
- R5: The resume byte 0x30 moves SUSPENDED to ERASING. Every other byte leaves SUSPENDED unchanged, and 0x30 in any other phase changes nothing.
- R6: `erase_done` in ERASING returns the block to IDLE and clears every sector mark, so later reads report array data (`resp_status` 0).
- R7: While SUSPENDED and with no program running, a read of a marked sector reports status (`resp_status` 1), and a read of an unmarked sector reports array data (0).
- R8: `resp_prog_ok` is 1 for a program in IDLE, or for a program to an unmarked sector while SUSPENDED. It is 0 in every other case.
- R9: While `prog_busy` is high, reads of unmarked sectors in SUSPENDED report status. Once it falls, they report array data again.
- R10: The status word bits are as follows. Bit 7 is 1 only in SUSPENDED. Bit 6 gives its current value and then flips on every read in WINDOW, ERASING or SUSPENDING, and it holds steady in SUSPENDED. Bit 2 flips the same way on reads of marked sectors in those phases and in SUSPENDED. All other bits are 0.
- R11: After reset the phase is IDLE, `busy`, `eng_run`, `eng_pause` and `resp_valid` are 0, no sector is marked, and both toggle bits are 0.
- R12: The phase codes are IDLE=0, WINDOW=1, ERASING=2, SUSPENDING=3 and SUSPENDED=4. `busy` is high in codes 1 to 3 and `eng_pause` in codes 3 and 4. An access replies one cycle after `acc_valid`, based on the phase at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_us | input | 1 | One-cycle pulse every microsecond |
| se_load | input | 1 | Sector-erase load from the decoder |
| se_sector | input | SECW | Sector named by the load |
| cmd_valid | input | 1 | Command byte strobe |
| cmd_byte | input | 8 | Command byte |
| chip_busy | input | 1 | Chip erase in progress |
| prog_busy | input | 1 | Embedded program in progress |
| eng_halted | input | 1 | Erase engine has stopped after a pause request |
| erase_done | input | 1 | Erase engine has finished |
| acc_valid | input | 1 | Read or program access strobe |
| acc_write | input | 1 | 1 for program, 0 for read |
| acc_sector | input | SECW | Sector of the access |
| phase | output | 3 | Current phase code |
| busy | output | 1 | Erase job busy |
| eng_run | output | 1 | Erase engine may run |
| eng_pause | output | 1 | Erase engine must pause |
| resp_valid | output | 1 | Access reply valid |
| resp_status | output | 1 | Reply is a status word, not array data |
| resp_word | output | 8 | Status word |
| resp_prog_ok | output | 1 | Program may proceed |

## Verification
A wrong phase register shows on the `phase`, `busy`, `eng_run` and `eng_pause` ports at the very next edge. Because of that, every stimulus cycle is compared against a phase model. A wrong sector mark or toggle register stays hidden until the next access. The bench therefore reads all sectors in each phase, so that such a fault shows in `resp_status` or `resp_word` within a few cycles. A miscounted window or latency timer shifts the step into ERASING or SUSPENDED by at least one tick.

// File: rtl/esr_pkg.sv
package esr_pkg;
  typedef enum logic [2:0] {
    PH_IDLE      = 3'd0,
    PH_WINDOW    = 3'd1,
    PH_ERASE     = 3'd2,
    PH_SUSPING   = 3'd3,
    PH_SUSPENDED = 3'd4
  } phase_e;

  localparam logic [7:0] CMD_SUSPEND = 8'hB0;
  localparam logic [7:0] CMD_RESUME  = 8'h30;

  function automatic logic ph_erasing(phase_e p);
    return (p == PH_WINDOW) || (p == PH_ERASE) || (p == PH_SUSPING);
  endfunction
endpackage

// File: rtl/esr_tick_timer.sv
module esr_tick_timer #(
  parameter int LIMIT = 50
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic run,
  input  logic tick,
  output logic hit
);
  localparam int CW = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);

  logic [CW-1:0] cnt;

  assign hit = run && tick && (cnt == CW'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (rst || clear)      cnt <= '0;
    else if (hit)          cnt <= '0;
    else if (run && tick)  cnt <= cnt + 1'b1;
  end

  // the count never passes the limit while the timer runs
  AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (rst)
    (run && !clear) |=> (cnt < CW'(LIMIT))); // R4
endmodule

// File: rtl/esr_sector_map.sv
module esr_sector_map #(
  parameter int NSEC = 32,
  parameter int SECW = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic [SECW-1:0] load_sec,
  input  logic            clr,
  input  logic [SECW-1:0] look_sec,
  output logic            sel_hit
);
  logic [NSEC-1:0] sel;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      sel <= '0;
    end else begin
      for (int i = 0; i < NSEC; i++) begin
        if (load && (load_sec == SECW'(i))) sel[i] <= 1'b1;
      end
    end
  end

  assign sel_hit = sel[look_sec];

  AST_SEL_LOADED: assert property (@(posedge clk) disable iff (rst)
    (load && !clr) |=> sel[$past(load_sec)]); // R2
  AST_SEL_CLEARED: assert property (@(posedge clk) disable iff (rst)
    clr |=> (sel == '0)); // R6
endmodule

// File: rtl/esr_resp.sv
module esr_resp
  import esr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       acc_valid,
  input  logic       acc_write,
  input  phase_e     ph,
  input  logic       sel_hit,
  input  logic       prog_busy,
  output logic       resp_valid,
  output logic       resp_status,
  output logic [7:0] resp_word,
  output logic       resp_prog_ok
);
  logic t6_q, t2_q;
  logic erasing, susp, rd, stat;

  assign erasing = ph_erasing(ph);
  assign susp    = (ph == PH_SUSPENDED);
  assign rd      = acc_valid && !acc_write;
  assign stat    = erasing || (susp && sel_hit) || prog_busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      t6_q         <= 1'b0;
      t2_q         <= 1'b0;
      resp_valid   <= 1'b0;
      resp_status  <= 1'b0;
      resp_word    <= '0;
      resp_prog_ok <= 1'b0;
    end else begin
      if (rd && erasing)                     t6_q <= ~t6_q;
      if (rd && sel_hit && (erasing || susp)) t2_q <= ~t2_q;
      resp_valid   <= acc_valid;
      resp_status  <= rd && stat;
      resp_word    <= rd ? {susp, t6_q, 3'b000, t2_q, 2'b00} : 8'h00;
      resp_prog_ok <= acc_valid && acc_write &&
                      ((ph == PH_IDLE) || (susp && !sel_hit));
    end
  end

  AST_DQ6_STEADY: assert property (@(posedge clk) disable iff (rst)
    (rd && susp) |=> $stable(t6_q)); // R10
  AST_DQ6_FLIP: assert property (@(posedge clk) disable iff (rst)
    (rd && erasing) |=> (t6_q != $past(t6_q))); // R10
endmodule

// File: rtl/esr_ctrl.sv
module esr_ctrl
  import esr_pkg::*;
#(
  parameter int NSEC    = 32,
  parameter int WIN_US  = 50,
  parameter int SUSP_US = 20,
  localparam int SECW   = (NSEC < 2) ? 1 : $clog2(NSEC)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tick_us,
  input  logic            se_load,
  input  logic [SECW-1:0] se_sector,
  input  logic            cmd_valid,
  input  logic [7:0]      cmd_byte,
  input  logic            chip_busy,
  input  logic            prog_busy,
  input  logic            eng_halted,
  input  logic            erase_done,
  input  logic            acc_valid,
  input  logic            acc_write,
  input  logic [SECW-1:0] acc_sector,
  output logic [2:0]      phase,
  output logic            busy,
  output logic            eng_run,
  output logic            eng_pause,
  output logic            resp_valid,
  output logic            resp_status,
  output logic [7:0]      resp_word,
  output logic            resp_prog_ok
);
  phase_e ph, ph_n;
  logic   susp_ok, resume_ok, win_hit, sus_hit, load_ok, clr_sel, sel_hit;

  assign susp_ok   = cmd_valid && (cmd_byte == CMD_SUSPEND) && !chip_busy &&
                     !prog_busy && ((ph == PH_WINDOW) || (ph == PH_ERASE));
  assign resume_ok = cmd_valid && (cmd_byte == CMD_RESUME) && (ph == PH_SUSPENDED);
  assign load_ok   = se_load && ((ph == PH_IDLE) || (ph == PH_WINDOW));
  assign clr_sel   = (ph == PH_ERASE) && erase_done && !susp_ok;

  esr_tick_timer #(.LIMIT(WIN_US)) u_win (
    .clk(clk), .rst(rst), .clear(se_load || (ph != PH_WINDOW)),
    .run(ph == PH_WINDOW), .tick(tick_us), .hit(win_hit));

  esr_tick_timer #(.LIMIT(SUSP_US)) u_sus (
    .clk(clk), .rst(rst), .clear(ph != PH_SUSPING),
    .run(ph == PH_SUSPING), .tick(tick_us), .hit(sus_hit));

  esr_sector_map #(.NSEC(NSEC), .SECW(SECW)) u_map (
    .clk(clk), .rst(rst), .load(load_ok), .load_sec(se_sector),
    .clr(clr_sel), .look_sec(acc_sector), .sel_hit(sel_hit));

  esr_resp u_resp (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
    .ph(ph), .sel_hit(sel_hit), .prog_busy(prog_busy),
    .resp_valid(resp_valid), .resp_status(resp_status),
    .resp_word(resp_word), .resp_prog_ok(resp_prog_ok));

  always_comb begin
    ph_n = ph;
    unique case (ph)
      PH_IDLE:      if (se_load) ph_n = PH_WINDOW;
      PH_WINDOW:    if (susp_ok)       ph_n = PH_SUSPENDED;
                    else if (se_load)  ph_n = PH_WINDOW;
                    else if (win_hit)  ph_n = PH_ERASE;
      PH_ERASE:     if (susp_ok)         ph_n = PH_SUSPING;
                    else if (erase_done) ph_n = PH_IDLE;
      PH_SUSPING:   if (eng_halted || sus_hit) ph_n = PH_SUSPENDED;
      PH_SUSPENDED: if (resume_ok) ph_n = PH_ERASE;
      default:      ph_n = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) ph <= PH_IDLE;
    else     ph <= ph_n;
  end

  assign phase     = ph;
  assign busy      = ph_erasing(ph);
  assign eng_run   = (ph == PH_ERASE);
  assign eng_pause = (ph == PH_SUSPING) || (ph == PH_SUSPENDED);

  AST_WIN_SUSP_NOW: assert property (@(posedge clk) disable iff (rst)
    ((ph == PH_WINDOW) && cmd_valid && (cmd_byte == CMD_SUSPEND) &&
     !chip_busy && !prog_busy) |=> (phase == 3'd4)); // R3
  AST_SUSP_IGNORED: assert property (@(posedge clk) disable iff (rst)
    ((ph == PH_ERASE) && cmd_valid && (cmd_byte == CMD_SUSPEND) &&
     (chip_busy || prog_busy) && !erase_done) |=> (phase == 3'd2)); // R1
  AST_SUSP_LIMIT: assert property (@(posedge clk) disable iff (rst)
    ((ph == PH_SUSPING) && sus_hit) |=> (phase == 3'd4)); // R4
  AST_RESUME_GO: assert property (@(posedge clk) disable iff (rst)
    ((ph == PH_SUSPENDED) && cmd_valid && (cmd_byte == CMD_RESUME))
    |=> eng_run); // R5
  AST_HOLD_SUSPENDED: assert property (@(posedge clk) disable iff (rst)
    ((ph == PH_SUSPENDED) && !(cmd_valid && (cmd_byte == CMD_RESUME)))
    |=> (phase == 3'd4)); // R5
endmodule

// File: tb/sim_esr_ctrl.sv
`timescale 1ns/100ps
module sim_esr_ctrl;
  localparam int NSEC = 8;
  localparam int WIN  = 4;
  localparam int SUSP = 3;
  localparam int SW   = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_us = 0, se_load = 0, cmd_valid = 0, chip_busy = 0, prog_busy = 0;
  logic eng_halted = 0, erase_done = 0, acc_valid = 0, acc_write = 0;
  logic [SW-1:0] se_sector = '0, acc_sector = '0;
  logic [7:0] cmd_byte = '0;
  logic [2:0] phase;
  logic busy, eng_run, eng_pause, resp_valid, resp_status, resp_prog_ok;
  logic [7:0] resp_word;

  always #2.5 clk = ~clk;

  esr_ctrl #(.NSEC(NSEC), .WIN_US(WIN), .SUSP_US(SUSP)) u0 (
    .clk(clk), .rst(rst), .tick_us(tick_us), .se_load(se_load),
    .se_sector(se_sector), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
    .chip_busy(chip_busy), .prog_busy(prog_busy), .eng_halted(eng_halted),
    .erase_done(erase_done), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_sector(acc_sector), .phase(phase), .busy(busy), .eng_run(eng_run),
    .eng_pause(eng_pause), .resp_valid(resp_valid), .resp_status(resp_status),
    .resp_word(resp_word), .resp_prog_ok(resp_prog_ok));

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  // model state
  int m_ph = 0, m_wc = 0, m_sc = 0;
  logic [NSEC-1:0] m_sel = '0;
  logic m_t6 = 0, m_t2 = 0;
  logic m_rv = 0, m_rs = 0, m_rp = 0;
  logic [7:0] m_rw = '0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_edge();
    int nph;
    logic susp, resume, wh, sh, erasing, sp, hit, rd;
    erasing = (m_ph >= 1 && m_ph <= 3);
    sp = (m_ph == 4);
    hit = m_sel[acc_sector];
    rd = acc_valid && !acc_write;
    m_rv = acc_valid;
    m_rs = rd && (erasing || (sp && hit) || prog_busy);
    m_rw = rd ? {sp, m_t6, 3'b000, m_t2, 2'b00} : 8'h00;
    m_rp = acc_valid && acc_write && (m_ph == 0 || (sp && !hit));
    if (rd && erasing) m_t6 = ~m_t6;
    if (rd && hit && (erasing || sp)) m_t2 = ~m_t2;
    susp = cmd_valid && cmd_byte == 8'hB0 && !chip_busy && !prog_busy &&
           (m_ph == 1 || m_ph == 2);
    resume = cmd_valid && cmd_byte == 8'h30 && sp;
    wh = (m_ph == 1) && tick_us && (m_wc == WIN - 1);
    sh = (m_ph == 3) && tick_us && (m_sc == SUSP - 1);
    nph = m_ph;
    case (m_ph)
      0: if (se_load) nph = 1;
      1: if (susp) nph = 4; else if (se_load) nph = 1; else if (wh) nph = 2;
      2: if (susp) nph = 3; else if (erase_done) nph = 0;
      3: if (eng_halted || sh) nph = 4;
      4: if (resume) nph = 2;
      default: nph = 0;
    endcase
    if (se_load || m_ph != 1) m_wc = 0; else if (wh) m_wc = 0; else if (tick_us) m_wc++;
    if (m_ph != 3) m_sc = 0; else if (sh) m_sc = 0; else if (tick_us) m_sc++;
    if (m_ph == 2 && erase_done && !susp) m_sel = '0;
    else if (se_load && (m_ph == 0 || m_ph == 1)) m_sel[se_sector] = 1'b1;
    m_ph = nph;
  endtask

  task automatic compare(input string tag);
    logic [5:0] ex;
    ex = {3'(m_ph), (m_ph >= 1 && m_ph <= 3), (m_ph == 2), (m_ph == 3 || m_ph == 4)};
    check({tag, " phase/busy/run/pause (R12)"}, 32'({phase, busy, eng_run, eng_pause}), 32'(ex));
    if (m_rv)
      check({tag, " reply"}, {20'd0, resp_valid, resp_status, resp_prog_ok, 1'b0, resp_word},
            {20'd0, 1'b1, m_rs, m_rp, 1'b0, m_rw});
    else
      check({tag, " no reply"}, 32'(resp_valid), 32'd0);
  endtask

  task automatic go(input string tag);
    model_edge();
    @(posedge clk); #1;
    compare(tag);
    tick_us = 0; se_load = 0; cmd_valid = 0; acc_valid = 0; erase_done = 0;
  endtask

  task automatic ticks(input int n, input string tag);
    for (int i = 0; i < n; i++) begin tick_us = 1; go(tag); end
  endtask
  task automatic load(input int s, input string tag);
    se_load = 1; se_sector = SW'(s); go(tag);
  endtask
  task automatic cmd(input logic [7:0] b, input string tag);
    cmd_valid = 1; cmd_byte = b; go(tag);
  endtask
  task automatic rd(input int s, input string tag);
    acc_valid = 1; acc_write = 0; acc_sector = SW'(s); go(tag);
  endtask
  task automatic wr(input int s, input string tag);
    acc_valid = 1; acc_write = 1; acc_sector = SW'(s); go(tag);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not end, actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0;
    // R11: reset state
    check("R11 reset phase/outputs", 32'({phase, busy, eng_run, eng_pause, resp_valid}), 32'd0);
    rd(0, "R11");
    wr(0, "R8 idle program");

    for (int s = 0; s < NSEC; s++) begin
      load(s, "R2 first load");
      load((s + 3) % NSEC, "R2 second load");
      ticks(WIN, "R2 window expiry");
      for (int k = 0; k < NSEC; k++) rd(k, "R10 erasing reads");
      chip_busy = 1; cmd(8'hB0, "R1 chip busy"); chip_busy = 0;
      prog_busy = 1; cmd(8'hB0, "R1 program busy"); prog_busy = 0;
      cmd(8'h30, "R5 resume in erasing");
      wr(s, "R8 program while erasing");
      cmd(8'hB0, "R4 suspend");
      rd(s, "R10 suspending read");
      if (s % 2 == 1) ticks(SUSP, "R4 latency limit");
      else begin eng_halted = 1; go("R4 engine halt"); eng_halted = 0; end
      for (int k = 0; k < NSEC; k++) rd(k, "R7 suspended reads");
      for (int k = 0; k < NSEC; k++) wr(k, "R8 suspended programs");
      rd(s, "R10 steady bit 6");
      prog_busy = 1; rd((s + 1) % NSEC, "R9 program running"); prog_busy = 0;
      rd((s + 1) % NSEC, "R9 program finished");
      cmd(8'hB0, "R1 suspend when suspended");
      cmd(8'h30, "R5 resume");
      erase_done = 1; go("R6 erase done");
      rd(s, "R6 read after erase");
      cmd(8'h30, "R5 resume idle");
      cmd(8'hB0, "R1 suspend idle");
    end

    // R3: suspend inside the window
    load(2, "R3 load");
    ticks(2, "R3 window");
    cmd(8'hB0, "R3 suspend in window");
    rd(2, "R7 marked");
    rd(5, "R7 unmarked");
    for (int b = 0; b < 256; b++)
      if (b != 8'h30) cmd(8'(b), "R5 other bytes");
    cmd(8'h30, "R5 resume");
    erase_done = 1; go("R6 done");

    // R2: window restart on a second load
    load(1, "R2 load");
    ticks(WIN - 1, "R2 window");
    load(4, "R2 restart");
    ticks(WIN - 1, "R2 restarted window");
    ticks(1, "R2 expiry");
    erase_done = 1; go("R6 done");

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule